// File: doc/BRIEF.md
# Special Register and I/O Channel Address Select Unit

This block turns the 12-bit memory address register value into select strobes for the eight low-address special registers and for the I/O channels. A register access uses the full address. A strobe fires only when every bit above the low 3-bit field is zero. A channel access looks only at the low six address bits. Every channel address therefore repeats across the upper address bits. Channel-access decoding stays correct even when an I/O instruction leaves bit 10 of the address set.

Two channel numbers, 1 and 2, have no channel hardware of their own. Accesses to them become the ordinary strobes for the registers at index 1 and index 2. The unit also holds the 3-bit erasable bank register. A register write to index 3 fills it from one field of the write lines. A register write to index 6 fills it from a different field. Between those writes the register keeps its value.

Top module: `addr_select_unit`

## Requirements
- R1: `low_page_o` is 1 exactly when address bits 12 down to 4 (`addr_i[11:3]`) are all zero.
- R2: When `reg_rd_i` or `reg_wr_i` is high and `low_page_o` is 1, the matching strobe `reg_rd_o[k]` or `reg_wr_o[k]` fires, where k = `addr_i[2:0]`. A register pulse at any address with `low_page_o` 0 fires no strobe.
- R3: In each cycle, `reg_rd_o` and `reg_wr_o` each carry at most one set bit.
- R4: A channel pulse (`chan_rd_i`/`chan_wr_i`) selects channel k = `addr_i[2:0]` only when `addr_i[5:3]` is zero. Bits `addr_i[11:6]`, including bit 10 (`addr_i[9]`), have no effect. So octal addresses 2, 102, 202, 302 and 1002 all select channel 2.
- R5: A channel pulse to channel 1 or 2 fires `reg_rd_o`/`reg_wr_o` bit 1 or bit 2 instead of a channel line. `chan_rd_o`/`chan_wr_o` bits 1 and 2 never go high.
- R6: A register write strobe at index 3 loads `wline_i[10:8]` (write-line bits 9 to 11) into `ebank_o`.
- R7: A register write strobe at index 6 loads `wline_i[2:0]` (write-line bits 1 to 3) into `ebank_o`.
- R8: `ebank_o` is 0 after reset. It holds its value in every cycle without a write strobe at index 3 or 6. This includes channel writes to channels 3 and 6, and register writes to aliased addresses such as octal 103.
- R9: `ebank_o` is registered. A load takes effect at the rising clock edge during which the write strobe is high, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 12 | Memory address register value; bit 0 is address bit 1 |
| reg_rd_i | input | 1 | Generic special-register read pulse |
| reg_wr_i | input | 1 | Generic special-register write pulse |
| chan_rd_i | input | 1 | Generic channel read pulse |
| chan_wr_i | input | 1 | Generic channel write pulse |
| wline_i | input | 16 | Write lines; bit 0 is line 1 |
| low_page_o | output | 1 | Address lies in the special-register page |
| reg_rd_o | output | 8 | Per-register read strobes, indexed by the low address field |
| reg_wr_o | output | 8 | Per-register write strobes, indexed by the low address field |
| chan_rd_o | output | 8 | Per-channel read selects (bits 1 and 2 unused) |
| chan_wr_o | output | 8 | Per-channel write selects (bits 1 and 2 unused) |
| ebank_o | output | 3 | Erasable bank register |

## Verification
Register pulses sweep all eight low indices inside the special page, then repeat with bits above the page boundary set. This separates a full-width page test from a decoder that looks only at the low field. Channel pulses use the same low index with octal prefixes 0, 100, 200, 300, 1000 and 7700, plus a nonzero middle field. These patterns show that aliasing covers exactly the upper six bits and no others. Bank loads drive the write lines with different values in the two candidate fields, so a load from the wrong field gives a visibly different result. Channel writes and aliased register writes at indices 3 and 6 then show that only genuine register writes move the bank value.

// File: rtl/addr_select_pkg.sv
package addr_select_pkg;
  localparam int unsigned ADDR_W_D  = 12;
  localparam int unsigned WORD_W_D  = 16;
  localparam int unsigned FLD_W_D   = 3;
  localparam int unsigned BANK_W_D  = 3;
  localparam int unsigned IDX_L     = 1;
  localparam int unsigned IDX_Q     = 2;
  localparam int unsigned IDX_EBANK = 3;
  localparam int unsigned IDX_BBANK = 6;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_HIGH = 2'd1,
    LD_LOW  = 2'd2
  } bank_src_e;
endpackage

// File: rtl/addr_rst_sync.sv
module addr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/addr_field_hot.sv
module addr_field_hot #(
  parameter int unsigned FLD_W = 3,
  localparam int unsigned NSEL = 1 << FLD_W
) (
  input  logic [FLD_W-1:0] field_i,
  output logic [NSEL-1:0]  hot_o
);
  for (genvar k = 0; k < NSEL; k++) begin : g_sel
    assign hot_o[k] = (field_i == FLD_W'(k));
  end
endmodule

// File: rtl/addr_bank_reg.sv
module addr_bank_reg
  import addr_select_pkg::*;
#(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned BANK_W  = 3,
  parameter int unsigned HI_LSB  = 8,
  parameter int unsigned LO_LSB  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [WORD_W-1:0] wline_i,
  output logic [BANK_W-1:0] bank_o
);
  bank_src_e         src;
  logic              bank_en;
  logic [BANK_W-1:0] bank_d;
  logic [BANK_W-1:0] bank_q;

  always_comb begin
    src = LD_NONE;
    if (ld_hi_i)      src = LD_HIGH;
    else if (ld_lo_i) src = LD_LOW;
  end

  always_comb begin
    bank_en = (src != LD_NONE);
    bank_d  = bank_q;
    case (src)
      LD_HIGH: bank_d = wline_i[HI_LSB +: BANK_W];
      LD_LOW:  bank_d = wline_i[LO_LSB +: BANK_W];
      default: bank_d = bank_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_en) bank_q <= bank_d;
  end

  assign bank_o = bank_q;
endmodule

// File: rtl/addr_select_unit.sv
module addr_select_unit
  import addr_select_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_D,
  parameter int unsigned WORD_W = WORD_W_D,
  parameter int unsigned FLD_W  = FLD_W_D,
  parameter int unsigned BANK_W = BANK_W_D,
  localparam int unsigned NSEL  = 1 << FLD_W,
  localparam int unsigned CH_W  = 2 * FLD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic              chan_rd_i,
  input  logic              chan_wr_i,
  input  logic [WORD_W-1:0] wline_i,
  output logic              low_page_o,
  output logic [NSEL-1:0]   reg_rd_o,
  output logic [NSEL-1:0]   reg_wr_o,
  output logic [NSEL-1:0]   chan_rd_o,
  output logic [NSEL-1:0]   chan_wr_o,
  output logic [BANK_W-1:0] ebank_o
);
  localparam logic [NSEL-1:0] CONV_MASK = NSEL'((1 << IDX_L) | (1 << IDX_Q));

  logic            rst_sync_n;
  logic [NSEL-1:0] lo_hot;
  logic            page_zero;
  logic            mid_zero;
  logic            reg_rd_g, reg_wr_g, chan_rd_g, chan_wr_g;

  addr_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  addr_field_hot #(.FLD_W(FLD_W)) i_lo_field (
    .field_i (addr_i[FLD_W-1:0]),
    .hot_o   (lo_hot)
  );

  assign page_zero = ~|addr_i[ADDR_W-1:FLD_W];
  assign mid_zero  = ~|addr_i[CH_W-1:FLD_W];

  assign reg_rd_g  = reg_rd_i  & page_zero;
  assign reg_wr_g  = reg_wr_i  & page_zero;
  assign chan_rd_g = chan_rd_i & mid_zero;
  assign chan_wr_g = chan_wr_i & mid_zero;

  assign low_page_o = page_zero;
  assign reg_rd_o   = ({NSEL{reg_rd_g}}  & lo_hot) | ({NSEL{chan_rd_g}} & lo_hot & CONV_MASK);
  assign reg_wr_o   = ({NSEL{reg_wr_g}}  & lo_hot) | ({NSEL{chan_wr_g}} & lo_hot & CONV_MASK);
  assign chan_rd_o  = {NSEL{chan_rd_g}} & lo_hot & ~CONV_MASK;
  assign chan_wr_o  = {NSEL{chan_wr_g}} & lo_hot & ~CONV_MASK;

  addr_bank_reg #(
    .WORD_W (WORD_W),
    .BANK_W (BANK_W),
    .HI_LSB (8),
    .LO_LSB (0)
  ) i_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ld_hi_i (reg_wr_o[IDX_EBANK]),
    .ld_lo_i (reg_wr_o[IDX_BBANK]),
    .wline_i (wline_i),
    .bank_o  (ebank_o)
  );
endmodule

// File: rtl/addr_select_chk.sv
module addr_select_chk
  import addr_select_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned FLD_W  = 3,
  parameter int unsigned BANK_W = 3,
  localparam int unsigned NSEL  = 1 << FLD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              reg_rd_i,
  input logic              chan_rd_i,
  input logic [WORD_W-1:0] wline_i,
  input logic [NSEL-1:0]   reg_rd_o,
  input logic [NSEL-1:0]   reg_wr_o,
  input logic [NSEL-1:0]   chan_rd_o,
  input logic [NSEL-1:0]   chan_wr_o,
  input logic [BANK_W-1:0] ebank_o
);
  a_r3_rd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_rd_o));
  a_r3_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_wr_o));
  a_r2_no_page_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && !chan_rd_i && |addr_i[ADDR_W-1:FLD_W]) |-> (reg_rd_o == '0));
  a_r4_mid_blocks_chan: assert property (@(posedge clk) disable iff (!rst_n)
    (|addr_i[2*FLD_W-1:FLD_W]) |-> (chan_rd_o == '0 && chan_wr_o == '0));
  a_r5_conv_q: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_rd_i && addr_i[2*FLD_W-1:0] == (2*FLD_W)'(IDX_Q)) |-> (reg_rd_o[IDX_Q] && chan_rd_o == '0));
  a_r6_load_high: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o[IDX_EBANK] |=> (ebank_o == $past(wline_i[8 +: BANK_W])));
  a_r7_load_low: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o[IDX_BBANK] |=> (ebank_o == $past(wline_i[0 +: BANK_W])));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_o[IDX_EBANK] && !reg_wr_o[IDX_BBANK]) |=> $stable(ebank_o));
endmodule

bind addr_select_unit addr_select_chk #(
  .ADDR_W (ADDR_W),
  .WORD_W (WORD_W),
  .FLD_W  (FLD_W),
  .BANK_W (BANK_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .addr_i    (addr_i),
  .reg_rd_i  (reg_rd_i),
  .chan_rd_i (chan_rd_i),
  .wline_i   (wline_i),
  .reg_rd_o  (reg_rd_o),
  .reg_wr_o  (reg_wr_o),
  .chan_rd_o (chan_rd_o),
  .chan_wr_o (chan_wr_o),
  .ebank_o   (ebank_o)
);

// File: tb/test_addr_select_unit.sv
`timescale 1ns/1ps
module test_addr_select_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr_i = '0;
  logic        reg_rd_i = 1'b0, reg_wr_i = 1'b0, chan_rd_i = 1'b0, chan_wr_i = 1'b0;
  logic [15:0] wline_i = '0;
  logic        low_page_o;
  logic [7:0]  reg_rd_o, reg_wr_o, chan_rd_o, chan_wr_o;
  logic [2:0]  ebank_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  addr_select_unit i_addr_select_unit (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i),
    .chan_rd_i(chan_rd_i), .chan_wr_i(chan_wr_i),
    .wline_i(wline_i), .low_page_o(low_page_o),
    .reg_rd_o(reg_rd_o), .reg_wr_o(reg_wr_o),
    .chan_rd_o(chan_rd_o), .chan_wr_o(chan_wr_o),
    .ebank_o(ebank_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // apply inputs at a falling edge, settle 1 ns
  task automatic drive(input logic [11:0] a, input logic rr, input logic rw,
                       input logic cr, input logic cw, input logic [15:0] wl);
    @(negedge clk);
    addr_i = a; reg_rd_i = rr; reg_wr_i = rw; chan_rd_i = cr; chan_wr_i = cw; wline_i = wl;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    reg_rd_i = 0; reg_wr_i = 0; chan_rd_i = 0; chan_wr_i = 0;
    #1;
  endtask

  task automatic t_reset();
    drive(12'o0, 0, 0, 0, 0, 16'h0);
    check("R8 reset bank", int'(ebank_o), 0);
    check("R2 idle rd strobes", int'(reg_rd_o), 0);
    check("R4 idle chan", int'(chan_rd_o | chan_wr_o), 0);
  endtask

  task automatic t_page_flag();
    drive(12'o0007, 0, 0, 0, 0, 16'h0); check("R1 page flag 7", int'(low_page_o), 1);
    drive(12'o0010, 0, 0, 0, 0, 16'h0); check("R1 page flag 10", int'(low_page_o), 0);
    drive(12'o4000, 0, 0, 0, 0, 16'h0); check("R1 page flag 4000", int'(low_page_o), 0);
    drive(12'o1002, 0, 0, 0, 0, 16'h0); check("R1 page flag 1002", int'(low_page_o), 0);
  endtask

  task automatic t_reg_strobes();
    for (int k = 0; k < 8; k++) begin
      drive(12'(k), 1, 0, 0, 0, 16'h0);
      check("R2 R3 rd strobe", int'(reg_rd_o), 1 << k);
      drive(12'(k), 0, 1, 0, 0, 16'h0);
      check("R2 R3 wr strobe", int'(reg_wr_o), 1 << k);
      drive(12'(k) | 12'o0100, 1, 0, 0, 0, 16'h0);
      check("R2 off-page rd", int'(reg_rd_o), 0);
    end
    idle();
  endtask

  task automatic t_chan_alias();
    logic [11:0] pre [6] = '{12'o0000, 12'o0100, 12'o0200, 12'o0300, 12'o1000, 12'o7700};
    for (int i = 0; i < 6; i++) begin
      drive(pre[i] | 12'o2, 0, 0, 1, 0, 16'h0);
      check("R5 R4 chan2 to Q read", int'(reg_rd_o), 1 << 2);
      check("R5 chan2 no line", int'(chan_rd_o), 0);
      drive(pre[i] | 12'o5, 0, 0, 0, 1, 16'h0);
      check("R4 chan5 alias write", int'(chan_wr_o), 1 << 5);
      check("R4 chan5 no reg", int'(reg_wr_o), 0);
    end
    drive(12'o0015, 0, 0, 1, 1, 16'h0);
    check("R4 mid field blocks", int'(chan_rd_o | chan_wr_o | reg_rd_o | reg_wr_o), 0);
    drive(12'o1101, 0, 0, 0, 1, 16'h0);
    check("R5 chan1 to L write", int'(reg_wr_o), 1 << 1);
    drive(12'o0000, 0, 0, 1, 0, 16'h0);
    check("R4 chan0 line", int'(chan_rd_o), 1);
    idle();
  endtask

  task automatic t_bank_high();
    drive(12'o0003, 0, 1, 0, 0, 16'b1010_1101_1111_1010);
    check("R9 no early load", int'(ebank_o), 0);
    idle();
    check("R6 load bits 9-11", int'(ebank_o), 5);
    drive(12'o0103, 0, 1, 0, 0, 16'h0700);
    idle();
    check("R8 aliased reg write ignored", int'(ebank_o), 5);
    drive(12'o0003, 0, 0, 0, 1, 16'h0200);
    idle();
    check("R8 chan3 write ignored", int'(ebank_o), 5);
  endtask

  task automatic t_bank_low();
    drive(12'o0006, 0, 1, 0, 0, 16'b0000_0111_0000_0011);
    idle();
    check("R7 load bits 1-3", int'(ebank_o), 3);
    drive(12'o0006, 0, 0, 0, 1, 16'h0006);
    idle();
    check("R8 chan6 write ignored", int'(ebank_o), 3);
    drive(12'o0003, 1, 0, 0, 0, 16'h0100);
    idle();
    check("R8 read does not load", int'(ebank_o), 3);
    drive(12'o0004, 0, 1, 0, 0, 16'h0707);
    idle();
    check("R8 other write holds", int'(ebank_o), 3);
  endtask

  initial begin
    #5 rst_n = 1'b0;
    #10 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_page_flag();
    t_reg_strobes();
    t_chan_alias();
    t_bank_high();
    t_bank_low();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule